// File: doc/BRIEF.md
# Table-Driven Host Clock Tick Divider

This block derives a controller-rate clock enable from a fast bus clock. The bus clock is divided by one of eight fixed, non-power-of-two ratios picked by a 3-bit code, and the result is a one-cycle tick. The block produces no real derived clock. Downstream logic that runs on the bus clock qualifies its work with the tick.

The code comes either from a manual input or from an automatic search. The search uses the bus clock frequency, supplied in MHz on an input. It walks from the largest ratio down and keeps the first code whose divided rate lies inside an inclusive window of 150 to 300 MHz. If no code fits, an error flag is raised and the tick stays quiet.

Configuration is taken only while a dedicated divider-reset input is held. The captured code and enable are reported on status outputs, so software can confirm that both match what it wrote. Releasing divider reset starts the count from zero, so a new ratio never produces a short first period.

Top module: `hclk_tick_div`

## Requirements
- R1: Select codes 0,1,2,3,4,5,6,7 give ratios N = 1,2,4,6,8,16,24,32. While running, `tick` is high for exactly one cycle in every N. Counting the first cycle after divider reset is released as cycle 0, the first tick falls in cycle N-1.
- R2: With ratio 1 (code 0) selected and the divider running, `tick` stays high in every cycle.
- R3: While `div_rst` is high, `tick` is low and the internal count is cleared. After release, the tick pattern restarts from cycle 0 as in R1.
- R4: `sel_in`, `clk_en`, `auto_sel` and `bus_freq_mhz` are captured only while `div_rst` is high. Changing them while it is low has no effect on `tick` or on the status outputs.
- R5: `stat_sel` and `stat_en` read back exactly the code and enable captured during the last divider reset.
- R6: If `clk_en` was low at capture, `tick` stays low.
- R7: With `auto_sel` high at capture, the chosen code is the highest code whose ratio N satisfies 150*N <= bus_freq_mhz <= 300*N. Both bounds are inclusive.
- R8: With `auto_sel` high and no code satisfying R7, `stat_err` is 1, `stat_sel` is 0 and `tick` stays low.
- R9: A manual capture (`auto_sel` low) always clears `stat_err`.
- R10: After synchronous reset (`rst_n` low), `tick`, `stat_sel`, `stat_en` and `stat_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_rst | input | 1 | Divider reset; high holds the count at zero and opens configuration capture |
| clk_en | input | 1 | Divider enable, captured during divider reset |
| auto_sel | input | 1 | 1 = pick the code automatically, 0 = use `sel_in` |
| sel_in | input | 3 | Manual select code |
| bus_freq_mhz | input | FREQ_W (16) | Bus clock frequency in MHz, used by the automatic search |
| tick | output | 1 | One-cycle controller clock enable |
| stat_sel | output | 3 | Active select code |
| stat_en | output | 1 | Active enable |
| stat_err | output | 1 | Automatic search found no fitting code |

## Verification
Every ratio is run for more than two periods. An off-by-one counter shows up as early or late ticks, a wrong table entry as the wrong spacing, and a divider that fails to hold ratio 1 high as gaps. The automatic search is driven at frequencies that hit both window bounds exactly and ones just outside them. One of these, 300 MHz, fits two codes; a search that scans upward returns code 0 there instead of code 1. In the middle of a run the bench changes the select and enable inputs, which catches a design that lets them through outside divider reset. It also asserts divider reset partway through a period; a counter that is not cleared then ticks too early after release.

// File: rtl/hcd_pkg.sv
// Shared definitions for the host clock tick divider.
// Assumes a fixed table of eight ratios addressed by a 3-bit code.
package hcd_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 1 << SEL_W;
    localparam int RATIO_MAX = 32;

    // Captured divider configuration.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             err;
    } hcd_cfg_t;

    // Map a select code to its division ratio.
    function automatic int unsigned code_ratio(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 16;
            3'd6:    return 24;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/hcd_auto_pick.sv
// Chooses the highest select code whose divided rate lies inside the
// inclusive frequency window. Each window test is folded into two constant
// multiplies, so no divider is built. Assumes FREQ_W <= 32.
module hcd_auto_pick #(
    parameter int FREQ_W      = 16,
    parameter int WIN_MIN_MHZ = 150,
    parameter int WIN_MAX_MHZ = 300
) (
    input  logic [FREQ_W-1:0]        freq_mhz,
    output logic [hcd_pkg::SEL_W-1:0] pick_sel,
    output logic                     pick_ok
);
    logic [hcd_pkg::NUM_CODES-1:0] fit;

    // One window comparator per code.
    for (genvar gi = 0; gi < hcd_pkg::NUM_CODES; gi++) begin : g_fit
        localparam int unsigned LO = WIN_MIN_MHZ * hcd_pkg::code_ratio(gi[hcd_pkg::SEL_W-1:0]);
        localparam int unsigned HI = WIN_MAX_MHZ * hcd_pkg::code_ratio(gi[hcd_pkg::SEL_W-1:0]);
        assign fit[gi] = (32'(freq_mhz) >= LO) && (32'(freq_mhz) <= HI);
    end

    // Priority toward the highest code, i.e. downward search, first hit wins.
    always_comb begin
        pick_ok  = 1'b0;
        pick_sel = '0;
        for (int k = 0; k < hcd_pkg::NUM_CODES; k++) begin
            if (fit[k]) begin
                pick_ok  = 1'b1;
                pick_sel = k[hcd_pkg::SEL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/hcd_cfg_reg.sv
// Holds the active divider configuration. Loads only while the divider
// reset is high; all inputs are ignored otherwise.
module hcd_cfg_reg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      div_rst,
    input  logic                      auto_sel,
    input  logic [hcd_pkg::SEL_W-1:0] sel_in,
    input  logic                      en_in,
    input  logic [hcd_pkg::SEL_W-1:0] pick_sel,
    input  logic                      pick_ok,
    output hcd_pkg::hcd_cfg_t         cfg
);
    // Capture select, enable and error during divider reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (div_rst) begin
            cfg.en <= en_in;
            if (auto_sel) begin
                cfg.sel <= pick_ok ? pick_sel : '0;
                cfg.err <= !pick_ok;
            end else begin
                cfg.sel <= sel_in;
                cfg.err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hcd_tick_cnt.sv
// Wrapping counter that emits one tick per selected ratio. Counts only when
// the divider is out of reset, enabled and error-free; otherwise held at 0.
module hcd_tick_cnt (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_rst,
    input  hcd_pkg::hcd_cfg_t cfg,
    output logic              tick
);
    localparam int CNT_W = $clog2(hcd_pkg::RATIO_MAX);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             run;

    // Terminal count and run qualifier.
    always_comb begin
        last = CNT_W'(hcd_pkg::code_ratio(cfg.sel) - 1);
        run  = !div_rst && cfg.en && !cfg.err;
        tick = run && (cnt == last);
    end

    // Advance or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hclk_tick_div.sv
// Top level of the host clock tick divider: automatic code search,
// configuration capture and tick counter. Assumes bus_freq_mhz is static
// while div_rst is high.
module hclk_tick_div #(
    parameter int FREQ_W      = 16,
    parameter int WIN_MIN_MHZ = 150,
    parameter int WIN_MAX_MHZ = 300
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      div_rst,
    input  logic                      clk_en,
    input  logic                      auto_sel,
    input  logic [hcd_pkg::SEL_W-1:0] sel_in,
    input  logic [FREQ_W-1:0]         bus_freq_mhz,
    output logic                      tick,
    output logic [hcd_pkg::SEL_W-1:0] stat_sel,
    output logic                      stat_en,
    output logic                      stat_err
);
    logic [hcd_pkg::SEL_W-1:0] pick_sel;
    logic                      pick_ok;
    hcd_pkg::hcd_cfg_t         cfg;

    hcd_auto_pick #(
        .FREQ_W     (FREQ_W),
        .WIN_MIN_MHZ(WIN_MIN_MHZ),
        .WIN_MAX_MHZ(WIN_MAX_MHZ)
    ) u_pick (
        .freq_mhz(bus_freq_mhz),
        .pick_sel(pick_sel),
        .pick_ok (pick_ok)
    );

    hcd_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_rst (div_rst),
        .auto_sel(auto_sel),
        .sel_in  (sel_in),
        .en_in   (clk_en),
        .pick_sel(pick_sel),
        .pick_ok (pick_ok),
        .cfg     (cfg)
    );

    hcd_tick_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_rst(div_rst),
        .cfg    (cfg),
        .tick   (tick)
    );

    // Status readback of the captured configuration.
    always_comb begin
        stat_sel = cfg.sel;
        stat_en  = cfg.en;
        stat_err = cfg.err;
    end
endmodule

// File: rtl/hclk_tick_div_chk.sv
// Assertion checker for hclk_tick_div, attached by bind. Tracks the gap
// between ticks with its own counter and checks it against the ratio table.
module hclk_tick_div_chk #(
    parameter int FREQ_W      = 16,
    parameter int WIN_MIN_MHZ = 150,
    parameter int WIN_MAX_MHZ = 300
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      div_rst,
    input logic                      auto_sel,
    input logic [FREQ_W-1:0]         bus_freq_mhz,
    input logic                      tick,
    input logic [hcd_pkg::SEL_W-1:0] stat_sel,
    input logic                      stat_en,
    input logic                      stat_err
);
    logic [5:0] gap;

    // Count running cycles since release or since the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n || div_rst || tick) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (32'(gap) == hcd_pkg::code_ratio(stat_sel) - 1));

    assert_gap_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_rst && stat_en && !stat_err) |-> (32'(gap) <= hcd_pkg::code_ratio(stat_sel) - 1));

    assert_quiet_in_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_rst) && div_rst) |-> !tick);

    assert_status_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_rst && !$past(div_rst)) |-> ($stable(stat_sel) && $stable(stat_en) && $stable(stat_err)));

    assert_no_tick_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |-> !tick);

    assert_auto_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_rst) && $past(auto_sel) && !stat_err) |->
        ((32'($past(bus_freq_mhz)) >= WIN_MIN_MHZ * hcd_pkg::code_ratio(stat_sel)) &&
         (32'($past(bus_freq_mhz)) <= WIN_MAX_MHZ * hcd_pkg::code_ratio(stat_sel))));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_err |-> (!tick && stat_sel == '0));

    assert_manual_clears_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_rst) && !$past(auto_sel)) |-> !stat_err);
endmodule

bind hclk_tick_div hclk_tick_div_chk #(
    .FREQ_W     (FREQ_W),
    .WIN_MIN_MHZ(WIN_MIN_MHZ),
    .WIN_MAX_MHZ(WIN_MAX_MHZ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_rst     (div_rst),
    .auto_sel    (auto_sel),
    .bus_freq_mhz(bus_freq_mhz),
    .tick        (tick),
    .stat_sel    (stat_sel),
    .stat_en     (stat_en),
    .stat_err    (stat_err)
);

// File: tb/hclk_tick_div_tb.sv
// Scoreboard bench: driver tasks queue the expected tick per cycle, a
// monitor pops and compares one entry on each falling edge.
module hclk_tick_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_rst = 1'b0;
    logic        clk_en = 1'b0;
    logic        auto_sel = 1'b0;
    logic [2:0]  sel_in = '0;
    logic [15:0] bus_freq_mhz = '0;
    logic        tick;
    logic [2:0]  stat_sel;
    logic        stat_en;
    logic        stat_err;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_tick_q[$];
    string exp_req_q[$];

    hclk_tick_div u_dut (
        .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .clk_en(clk_en),
        .auto_sel(auto_sel), .sel_in(sel_in), .bus_freq_mhz(bus_freq_mhz),
        .tick(tick), .stat_sel(stat_sel), .stat_en(stat_en), .stat_err(stat_err)
    );

    always #5 clk = ~clk;

    function automatic int ratio_of(input int code);
        int r[8] = '{1, 2, 4, 6, 8, 16, 24, 32};
        return r[code];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare tick against the queued expectation.
    always @(negedge clk) begin
        if (exp_tick_q.size() > 0) begin
            bit    e;
            string r;
            e = exp_tick_q.pop_front();
            r = exp_req_q.pop_front();
            check(tick === e, r, int'(tick), int'(e));
        end
    end

    // Configure through a divider reset, then run n cycles of expectations.
    task automatic run_cfg(input bit a, input int s, input bit e, input int f,
                           input int exp_sel, input bit exp_err, input int n,
                           input bit glitch, input string req);
        int r;
        @(posedge clk); #1;
        div_rst = 1'b1; auto_sel = a; sel_in = 3'(s); clk_en = e; bus_freq_mhz = 16'(f);
        @(posedge clk); #1;
        div_rst = 1'b0;
        r = ratio_of(exp_sel);
        for (int k = 0; k < n; k++) begin
            exp_tick_q.push_back(e && !exp_err && ((k % r) == r - 1));
            exp_req_q.push_back(req);
        end
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (glitch && i == n / 2) begin
                sel_in = ~sel_in; clk_en = ~clk_en; auto_sel = ~auto_sel;
                bus_freq_mhz = 16'd100;
            end
        end
        wait (exp_tick_q.size() == 0);
        check(int'(stat_sel) == exp_sel, {req, " R5 stat_sel"}, int'(stat_sel), exp_sel);
        check(stat_en == e, {req, " R5 stat_en"}, int'(stat_en), int'(e));
        check(stat_err == exp_err, {req, " stat_err"}, int'(stat_err), int'(exp_err));
    endtask

    // Hold divider reset for n cycles, expecting a quiet tick.
    task automatic hold_rst(input int n);
        @(posedge clk); #1;
        div_rst = 1'b1;
        for (int k = 0; k < n; k++) begin
            exp_tick_q.push_back(1'b0);
            exp_req_q.push_back("R3 quiet in divider reset");
        end
        repeat (n) @(posedge clk);
        wait (exp_tick_q.size() == 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(tick == 1'b0, "R10 tick", int'(tick), 0);
        check(stat_sel == 3'd0, "R10 stat_sel", int'(stat_sel), 0);
        check(stat_en == 1'b0, "R10 stat_en", int'(stat_en), 0);
        check(stat_err == 1'b0, "R10 stat_err", int'(stat_err), 0);
        rst_n = 1'b1;

        // R1/R2/R9: every manual code
        for (int c = 0; c < 8; c++)
            run_cfg(1'b0, c, 1'b1, 0, c, 1'b0, 2 * ratio_of(c) + 3, 1'b0,
                    c == 0 ? "R2 ratio one" : "R1 manual ratio");

        // R4: inputs changed mid-run are ignored
        run_cfg(1'b0, 3, 1'b1, 0, 3, 1'b0, 20, 1'b1, "R4 ignore mid-run");

        // R6: enable low gives no ticks
        run_cfg(1'b0, 2, 1'b0, 0, 2, 1'b0, 12, 1'b0, "R6 disabled");

        // R3: divider reset mid-period, restart from zero
        run_cfg(1'b0, 2, 1'b1, 0, 2, 1'b0, 6, 1'b0, "R3 before hold");
        hold_rst(3);
        run_cfg(1'b0, 2, 1'b1, 0, 2, 1'b0, 9, 1'b0, "R3 restart");
        run_cfg(1'b0, 0, 1'b1, 0, 0, 1'b0, 4, 1'b0, "R2 before hold");
        hold_rst(2);

        // R7: automatic search, including window bounds
        run_cfg(1'b1, 5, 1'b1, 1000, 3, 1'b0, 14, 1'b0, "R7 auto 1000");
        run_cfg(1'b1, 5, 1'b1, 300,  1, 1'b0, 6,  1'b0, "R7 auto 300 downward");
        run_cfg(1'b1, 5, 1'b1, 200,  0, 1'b0, 4,  1'b0, "R7 auto 200");
        run_cfg(1'b1, 5, 1'b1, 150,  0, 1'b0, 4,  1'b0, "R7 auto 150 lower bound");
        run_cfg(1'b1, 0, 1'b1, 1200, 4, 1'b0, 18, 1'b0, "R7 auto 1200");
        run_cfg(1'b1, 0, 1'b1, 4800, 7, 1'b0, 66, 1'b0, "R7 auto 4800");
        run_cfg(1'b1, 0, 1'b1, 9600, 7, 1'b0, 66, 1'b0, "R7 auto 9600 upper bound");

        // R8: no fitting code
        run_cfg(1'b1, 6, 1'b1, 100,  0, 1'b1, 10, 1'b0, "R8 auto none 100");
        run_cfg(1'b1, 6, 1'b1, 9601, 0, 1'b1, 10, 1'b0, "R8 auto none 9601");

        // R9: manual capture clears the error
        run_cfg(1'b0, 1, 1'b1, 9601, 1, 1'b0, 6, 1'b0, "R9 manual clears err");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule